// File: doc/BRIEF.md
# Watchdog Timer with Shared Kick/Clear Bit and Sticky Overflow Flag

This block is a watchdog timer for a processor subsystem. Software keeps the watchdog from expiring by writing a 1 to a single control bit. The same bit serves a second purpose. Reading it returns an unrelated event flag, typically a clock-loss interrupt flag that the `evt_in` input sets. Writing it with 0 clears that event flag and leaves the watchdog alone. If software stops writing 1 for a full timeout window, the block raises a one-cycle reset request. The system reset generator is expected to turn that request into a core reset.

The block also keeps an overflow flag in an always-on register. The core reset `rst_n`, which the watchdog's own request leads to, does not clear this flag. After boot, software can read it to tell a watchdog recovery from a power fault, and then clear it. The external reset pin `ext_rst` clears the flag for as long as it is high.

The watchdog logic is a two-state machine. In state COUNT the counter advances. Transition COUNT→FIRE is taken when the counter sits at its last value and no kick arrives. In state FIRE the request is high. Transition FIRE→COUNT is unconditional and leaves the counter at zero.

Top module: `wdk_top`

## Requirements
- R1: A cycle with `evt_in` high sets the event flag at the next clock edge. `ctl_rdata` always returns the event flag.
- R2: A control write with `ctl_wdata`=0 clears the event flag at the next edge and does not restart the watchdog counter.
- R3: A control write with `ctl_wdata`=1 restarts the watchdog counter and leaves the event flag unchanged.
- R4: When `evt_in` and a write-0 clear fall in the same cycle, the event flag is 1 after the edge.
- R5: When kicks come at least once every `TIMEOUT_CYCLES` edges, `wd_rst_req` stays 0.
- R6: Without a kick, `wd_rst_req` goes high after exactly `TIMEOUT_CYCLES` edges, counted from the kick edge or from reset release. The counter then restarts from zero.
- R7: `wd_rst_req` is a single-cycle pulse.
- R8: The overflow flag `ovf_rdata` becomes 1 at the same edge on which `wd_rst_req` rises, and keeps its value while `rst_n` is low.
- R9: A write of `ovf_wdata` through `ovf_wr` loads the overflow flag at the next edge.
- R10: While `ext_rst` is high, the overflow flag is 0 (asynchronous clear), and software writes to it are ignored.
- R11: When an overflow and a software write of 0 to the overflow flag fall on the same edge, the flag is 1.
- R12: While `rst_n` is low, the event flag is 0, `wd_rst_req` is 0 and the counter is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Core reset, active low, asynchronous |
| ext_rst | input | 1 | External reset pin, active high; clears the overflow flag |
| ctl_wr | input | 1 | Control bit write strobe |
| ctl_wdata | input | 1 | Control bit write value: 1 kicks, 0 clears event flag |
| ctl_rdata | output | 1 | Control bit read value, equal to the event flag |
| evt_in | input | 1 | Event that sets the event flag |
| ovf_wr | input | 1 | Overflow flag write strobe |
| ovf_wdata | input | 1 | Overflow flag write value |
| ovf_rdata | output | 1 | Overflow flag (always-on) |
| wd_rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is the event input and the write-0 clear of the event flag. The bench raises `evt_in` in the same cycle as a control write of 0 and expects the flag to read 1 after the edge.

The second pair is a timeout and a software clear of the overflow flag. The bench kicks the watchdog, counts `TIMEOUT_CYCLES` idle edges, and puts an overflow write of 0 on exactly the edge where the request fires. It then expects the request high and the overflow flag still 1.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    typedef enum logic [0:0] {
        WDS_COUNT = 1'b0,
        WDS_FIRE  = 1'b1
    } wds_e;
endpackage

// File: rtl/wdk_timer.sv
module wdk_timer
    import wdk_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic ovf_set_o,
    output logic req_o
);
    localparam int CW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

    wds_e        state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic        at_last;

    assign at_last = (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WDS_COUNT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WDS_COUNT: if (at_last && !kick_i) state_d = WDS_FIRE;
            WDS_FIRE:  state_d = WDS_COUNT;
        endcase
    end

    // outputs
    always_comb begin
        req_o     = (state_q == WDS_FIRE);
        ovf_set_o = (state_q == WDS_COUNT) && at_last && !kick_i;
    end

    // timeout counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (kick_i)                cnt_q <= '0;
        else if (state_q == WDS_FIRE)   cnt_q <= '0;
        else if (at_last)               cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdk_evt_flag.sv
module wdk_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // set has priority over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/wdk_aon_flag.sv
module wdk_aon_flag (
    input  logic clk,
    input  logic clr_async_i,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic flag_o
);
    // always-on: untouched by the core reset; only the external pin clears it
    always_ff @(posedge clk or posedge clr_async_i) begin
        if (clr_async_i) flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (wr_i)   flag_o <= wdata_i;
    end
endmodule

// File: rtl/wdk_top.sv
module wdk_top #(
    parameter int TIMEOUT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_rst,
    input  logic ctl_wr,
    input  logic ctl_wdata,
    output logic ctl_rdata,
    input  logic evt_in,
    input  logic ovf_wr,
    input  logic ovf_wdata,
    output logic ovf_rdata,
    output logic wd_rst_req
);
    logic kick, evt_clr, ovf_set;

    assign kick    = ctl_wr &  ctl_wdata;
    assign evt_clr = ctl_wr & ~ctl_wdata;

    wdk_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick_i    (kick),
        .ovf_set_o (ovf_set),
        .req_o     (wd_rst_req)
    );

    wdk_evt_flag evt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_in),
        .clr_i  (evt_clr),
        .flag_o (ctl_rdata)
    );

    wdk_aon_flag aon_i (
        .clk         (clk),
        .clr_async_i (ext_rst),
        .set_i       (ovf_set),
        .wr_i        (ovf_wr),
        .wdata_i     (ovf_wdata),
        .flag_o      (ovf_rdata)
    );
endmodule

// File: rtl/wdk_chk.sv
module wdk_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_rst,
    input logic ctl_wr,
    input logic ctl_wdata,
    input logic ctl_rdata,
    input logic evt_in,
    input logic ovf_wr,
    input logic ovf_wdata,
    input logic ovf_rdata,
    input logic wd_rst_req
);
    // R1 and R4: an event sets the flag even against a clear
    a_r1_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt_in |=> ctl_rdata);

    // R2
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata && !evt_in) |=> !ctl_rdata);

    // R3
    a_r3_kick_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata && !evt_in) |=> (ctl_rdata == $past(ctl_rdata)));

    // R5
    a_r5_kick_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata) |=> !wd_rst_req);

    // R7
    a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wd_rst_req |=> !wd_rst_req);

    // R8 and R11: overflow flag is set together with the request
    a_r8_ovf_on_req: assert property (@(posedge clk) disable iff (ext_rst || !rst_n)
        $rose(wd_rst_req) |-> ovf_rdata);

    // R8: persistence through core reset
    a_r8_persist: assert property (@(posedge clk) disable iff (ext_rst)
        (!rst_n && $past(ovf_rdata) && !$past(ovf_wr)) |-> ovf_rdata);

    // R10
    always @(posedge clk) begin
        if (ext_rst) a_r10_ext_clear: assert (!ovf_rdata);
    end

    // R12
    always @(posedge clk) begin
        if (!rst_n) a_r12_reset_quiet: assert (!wd_rst_req && !ctl_rdata);
    end
endmodule

bind wdk_top wdk_chk chk_i (.*);

// File: tb/wdk_top_tb_top.sv
module wdk_top_tb_top;
    localparam int TO = 16;

    logic clk = 1'b0;
    logic rst_n, ext_rst, ctl_wr, ctl_wdata, evt_in, ovf_wr, ovf_wdata;
    logic ctl_rdata, ovf_rdata, wd_rst_req;

    always #2 clk = ~clk; // 250 MHz

    wdk_top #(.TIMEOUT_CYCLES(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .evt_in(evt_in), .ovf_wr(ovf_wr), .ovf_wdata(ovf_wdata),
        .ovf_rdata(ovf_rdata), .wd_rst_req(wd_rst_req)
    );

    typedef struct {
        string rq;
        int    sel;   // 0: ctl_rdata, 1: ovf_rdata, 2: wd_rst_req
        bit    exp;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;

    // scoreboard expectation; judged just after the next rising edge
    task automatic expect_bit(input string rq, input int sel, input bit exp);
        item_t it;
        it.rq = rq; it.sel = sel; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic drive(input bit wr, input bit wd, input bit ev, input bit owr, input bit owd);
        @(negedge clk);
        ctl_wr = wr; ctl_wdata = wd; evt_in = ev; ovf_wr = owr; ovf_wdata = owd;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                item_t it;
                logic act;
                it = q.pop_front();
                act = (it.sel == 0) ? ctl_rdata : (it.sel == 1) ? ovf_rdata : wd_rst_req;
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s sel=%0d actual=%b expected=%b at %0t",
                             it.rq, it.sel, act, it.exp, $time);
                end
            end
        end
    end

    // hang guard
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ext_rst = 1;
        ctl_wr = 0; ctl_wdata = 0; evt_in = 0; ovf_wr = 0; ovf_wdata = 0;
        repeat (3) drive(0, 0, 0, 0, 0);
        expect_bit("R12", 0, 0);
        expect_bit("R12", 2, 0);
        expect_bit("R10", 1, 0);
        @(negedge clk);
        ext_rst = 0; rst_n = 1;

        // event flag behaviour
        drive(0, 0, 1, 0, 0); expect_bit("R1", 0, 1);
        drive(0, 0, 0, 0, 0); expect_bit("R1", 0, 1);
        drive(1, 1, 0, 0, 0); expect_bit("R3", 0, 1);
        drive(1, 0, 0, 0, 0); expect_bit("R2", 0, 0);
        drive(1, 0, 1, 0, 0); expect_bit("R4", 0, 1);
        drive(1, 0, 0, 0, 0); expect_bit("R2", 0, 0);

        // regular kicks: never a request
        for (int i = 0; i < 60; i++) begin
            drive((i % 10) == 0, 1, 0, 0, 0);
            expect_bit("R5", 2, 0);
        end

        // timeout after TO idle edges; a write-0 in the window does not restart
        drive(1, 1, 0, 0, 0); expect_bit("R3", 2, 0);
        for (int j = 1; j <= TO + 1; j++) begin
            if (j == 8) drive(1, 0, 0, 0, 0);
            else        drive(0, 0, 0, 0, 0);
            if (j == 8)  expect_bit("R2", 2, 0);
            else if (j == TO) expect_bit("R6", 2, 1);
            else if (j == TO + 1) expect_bit("R7", 2, 0);
            else expect_bit("R6", 2, 0);
            if (j == TO) expect_bit("R8", 1, 1);
        end

        // core reset caused by the request: overflow flag survives
        drive(0, 0, 1, 0, 0);
        expect_bit("R1", 0, 1);
        for (int k = 0; k < 3; k++) begin
            drive(0, 0, 0, 0, 0);
            rst_n = 0;
            expect_bit("R8", 1, 1);
            expect_bit("R12", 2, 0);
            expect_bit("R12", 0, 0);
        end
        drive(0, 0, 0, 0, 0); rst_n = 1; expect_bit("R8", 1, 1);

        // software access and external reset
        drive(0, 0, 0, 1, 0); expect_bit("R9", 1, 0);
        drive(0, 0, 0, 1, 1); expect_bit("R9", 1, 1);
        drive(0, 0, 0, 0, 0); ext_rst = 1; expect_bit("R10", 1, 0);
        drive(0, 0, 0, 1, 1); expect_bit("R10", 1, 0);
        drive(0, 0, 0, 0, 0); ext_rst = 0; expect_bit("R10", 1, 0);

        // overflow collides with a software clear
        drive(1, 1, 0, 0, 0); expect_bit("R3", 2, 0);
        for (int j = 1; j <= TO + 1; j++) begin
            if (j == TO) drive(0, 0, 0, 1, 0);
            else         drive(0, 0, 0, 0, 0);
            if (j == TO) begin
                expect_bit("R11", 2, 1);
                expect_bit("R11", 1, 1);
            end else if (j == TO + 1) begin
                expect_bit("R11", 1, 1);
            end else begin
                expect_bit("R6", 2, 0);
            end
        end

        repeat (3) drive(0, 0, 0, 0, 0);
        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule